// File: doc/BRIEF.md
# Revolution-Counted Head Unload Timer

This block keeps one floppy drive's idle timer. Once the drive has been selected, the timer counts media revolutions, one per index pulse, for as long as no data transfer takes place. When the count reaches a programmable limit, the block unloads the head and deselects the drive in the same clock. It also raises a one-clock event so that the controller's sequencer knows the drive has gone idle.

Any transfer activity restarts the idle count, and so does a fresh select. The limit is 16 revolutions after reset. A command can change it to any value from 1 to 255. While the drive is deselected, the timer stays at zero and ignores index pulses and activity. The index input comes from the drive asynchronously and is synchronised inside the block.

Top module: `rev_unload_timer`

## Requirements
- R1: After reset, `head_load`, `drive_sel` and `unload_evt` are 0 and the limit is 16.
- R2: With the reset limit, a selected drive with no activity stays selected through 15 revolutions and is released on the 16th.
- R3: A pulse on `limit_wr` with a `limit_val` from 1 to 255 sets the limit to that value. Limits of 1 and 255 are both honoured.
- R4: A `limit_wr` pulse with `limit_val` equal to 0 is ignored, and the previous limit stays in force.
- R5: One revolution is counted per rising edge of the synchronised `index_raw`. Holding the index high for many clocks counts only once.
- R6: A `xfer_stb` pulse while the drive is selected restarts the idle count from zero. If it falls in the same clock as the revolution that would reach the limit, the drive stays selected.
- R7: At timeout, `head_load` and `drive_sel` fall together in the same clock, and they are always equal.
- R8: `unload_evt` is high for exactly one clock, in the first clock in which `drive_sel` is low after the timeout.
- R9: While the drive is deselected, the count holds at zero, and index pulses and `xfer_stb` cause no selection and no event.
- R10: A `select_stb` pulse sets `head_load` and `drive_sel` and restarts the count from zero.
- R11: If the limit is lowered to or below the current count, the drive is released at the next revolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| index_raw | input | 1 | Index pulse from the drive, asynchronous |
| select_stb | input | 1 | One-clock request to select the drive and load the head |
| xfer_stb | input | 1 | One-clock strobe on each burst of transfer activity |
| limit_wr | input | 1 | One-clock strobe that writes a new revolution limit |
| limit_val | input | 8 | New limit in revolutions; 0 is ignored |
| head_load | output | 1 | Head load enable |
| drive_sel | output | 1 | Drive select enable |
| unload_evt | output | 1 | One-clock event when the drive is released |

## Verification
The collision that matters is a transfer strobe that arrives in the same clock as the revolution tick which would reach the limit. The bench provokes it by timing `xfer_stb` against the index synchroniser delay so that both land on the same edge. It then checks that no event is raised and that the next full limit of revolutions is needed before release. A second overlap, a limit write that drops below the count already reached, is judged by expecting the release at the next revolution.

// File: rtl/hut_pkg.sv
package hut_pkg;
  localparam int unsigned LIMIT_W       = 8;
  localparam int unsigned DEFAULT_LIMIT = 16;
  localparam int unsigned SYNC_STAGES   = 2;
  typedef logic [LIMIT_W-1:0] limit_t;
endpackage

// File: rtl/hut_index_sync.sv
module hut_index_sync #(
  parameter int unsigned STAGES = hut_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic index_raw,
  output logic rev_tick
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d   = {sync_q[STAGES-2:0], index_raw};
    rev_tick = sync_q[STAGES-1] & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  // R5: a single edge yields a single tick
  a_r5_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
    rev_tick |=> !rev_tick);
endmodule

// File: rtl/hut_limit_reg.sv
module hut_limit_reg
  import hut_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr,
  input  limit_t val,
  output limit_t limit
);
  limit_t lim_q;
  limit_t lim_d;
  logic   wr_ok;

  always_comb begin
    wr_ok = wr && (val != '0);
    lim_d = wr_ok ? val : lim_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lim_q <= limit_t'(DEFAULT_LIMIT);
    else        lim_q <= lim_d;
  end

  assign limit = lim_q;

  // R4: zero writes leave the limit unchanged
  a_r4_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && val == '0) |=> $stable(limit));
  // R3: the limit is never zero
  a_r3_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    limit != '0);
endmodule

// File: rtl/hut_idle_counter.sv
module hut_idle_counter
  import hut_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   selected,
  input  logic   restart,
  input  logic   rev_tick,
  input  limit_t limit,
  output logic   expire
);
  localparam int unsigned CW = LIMIT_W + 1;

  limit_t       cnt_q;
  limit_t       cnt_d;
  logic [CW-1:0] cnt_next;

  always_comb begin
    cnt_next = {1'b0, cnt_q} + CW'(1);
    expire   = selected && !restart && rev_tick && (cnt_next >= {1'b0, limit});
    cnt_d    = cnt_q;
    if (!selected || restart || expire) cnt_d = '0;
    else if (rev_tick)                  cnt_d = cnt_next[LIMIT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9: count held at zero while deselected
  a_r9_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !selected |=> cnt_q == '0);
  // R6: activity clears the idle count
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0);
endmodule

// File: rtl/rev_unload_timer.sv
module rev_unload_timer
  import hut_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               index_raw,
  input  logic               select_stb,
  input  logic               xfer_stb,
  input  logic               limit_wr,
  input  logic [LIMIT_W-1:0] limit_val,
  output logic               head_load,
  output logic               drive_sel,
  output logic               unload_evt
);
  logic   rev_tick;
  logic   expire;
  logic   restart;
  limit_t limit;

  logic sel_q, sel_d;
  logic head_q, head_d;
  logic evt_q, evt_d;

  hut_index_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .index_raw(index_raw), .rev_tick(rev_tick));

  hut_limit_reg u_limit (
    .clk(clk), .rst_n(rst_n), .wr(limit_wr), .val(limit_val), .limit(limit));

  hut_idle_counter u_count (
    .clk(clk), .rst_n(rst_n), .selected(sel_q), .restart(restart),
    .rev_tick(rev_tick), .limit(limit), .expire(expire));

  always_comb begin
    restart = select_stb | xfer_stb;
    sel_d   = sel_q;
    head_d  = head_q;
    if (select_stb) begin
      sel_d  = 1'b1;
      head_d = 1'b1;
    end else if (expire) begin
      sel_d  = 1'b0;
      head_d = 1'b0;
    end
    evt_d = expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      head_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      head_q <= head_d;
      evt_q  <= evt_d;
    end
  end

  assign head_load  = head_q;
  assign drive_sel  = sel_q;
  assign unload_evt = evt_q;

  // R7: head and select move together
  a_r7_together: assert property (@(posedge clk) disable iff (!rst_n)
    head_load == drive_sel);
  // R8: event lasts one clock
  a_r8_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    unload_evt |=> !unload_evt);
  // R8: event coincides with release
  a_r8_with_release: assert property (@(posedge clk) disable iff (!rst_n)
    unload_evt |-> (!drive_sel && $past(drive_sel)));
  // R10: select strobe always selects
  a_r10_select: assert property (@(posedge clk) disable iff (!rst_n)
    select_stb |=> drive_sel);
endmodule

// File: tb/rev_unload_timer_test.sv
module rev_unload_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       index_raw = 1'b0;
  logic       select_stb = 1'b0;
  logic       xfer_stb = 1'b0;
  logic       limit_wr = 1'b0;
  logic [7:0] limit_val = 8'd0;
  logic       head_load, drive_sel, unload_evt;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int exp_q[$];
  int m_count = 0;
  int m_limit = 16;
  bit m_sel = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rev_unload_timer uut (
    .clk(clk), .rst_n(rst_n), .index_raw(index_raw), .select_stb(select_stb),
    .xfer_stb(xfer_stb), .limit_wr(limit_wr), .limit_val(limit_val),
    .head_load(head_load), .drive_sel(drive_sel), .unload_evt(unload_evt));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: pops expected event cycles (R8, R7)
  always @(negedge clk) begin
    if (rst_n && unload_evt) begin
      if (exp_q.size() == 0) chk(0, "R8 unexpected event", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R8 event cycle", cyc, e);
        chk(!drive_sel && !head_load, "R7 release together", drive_sel + head_load, 0);
      end
    end
  end

  task automatic model_tick(input bit collide, input int c0);
    if (!m_sel) return;
    if (collide) begin m_count = 0; return; end
    m_count++;
    if (m_count >= m_limit) begin
      exp_q.push_back(c0 + 3);
      m_sel = 0;
      m_count = 0;
    end
  endtask

  // one revolution; hi = clocks the index stays high
  task automatic rev(input int hi = 2, input bit collide = 0);
    int c0;
    @(negedge clk);
    c0 = cyc;
    index_raw = 1'b1;
    model_tick(collide, c0);
    @(negedge clk);
    @(negedge clk);
    if (collide) xfer_stb = 1'b1;
    @(negedge clk);
    xfer_stb = 1'b0;
    for (int i = 3; i < hi; i++) @(negedge clk);
    index_raw = 1'b0;
    repeat (3) @(negedge clk);
    chk(drive_sel == m_sel, "R2/R5 select after revolution", drive_sel, m_sel);
  endtask

  task automatic revs(input int n);
    for (int i = 0; i < n; i++) rev();
  endtask

  task automatic do_select();
    @(negedge clk);
    select_stb = 1'b1;
    @(negedge clk);
    select_stb = 1'b0;
    m_sel = 1; m_count = 0;
    chk(drive_sel && head_load, "R10 select", drive_sel, 1);
  endtask

  task automatic do_xfer();
    @(negedge clk);
    xfer_stb = 1'b1;
    @(negedge clk);
    xfer_stb = 1'b0;
    if (m_sel) m_count = 0;
  endtask

  task automatic do_load(input int v);
    @(negedge clk);
    limit_wr = 1'b1; limit_val = 8'(v);
    @(negedge clk);
    limit_wr = 1'b0;
    if (v != 0) m_limit = v;
  endtask

  initial begin
    #2_000_000;
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!head_load && !drive_sel && !unload_evt, "R1 reset outputs",
        head_load + drive_sel + unload_evt, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: default limit 16
    do_select();
    revs(15);
    chk(drive_sel == 1, "R2 still selected after 15", drive_sel, 1);
    rev();
    chk(drive_sel == 0, "R2 released at 16", drive_sel, 0);

    // R5: long index high counts once
    do_select();
    rev(20);
    revs(14);
    chk(drive_sel == 1, "R5 long pulse counted once", drive_sel, 1);
    rev();

    // R6: activity restarts count
    do_select();
    revs(10);
    do_xfer();
    revs(15);
    chk(drive_sel == 1, "R6 restart after activity", drive_sel, 1);
    rev();
    chk(drive_sel == 0, "R6 release after full limit", drive_sel, 0);

    // R3: limit 3, R4: zero ignored
    do_load(3);
    do_load(0);
    do_select();
    revs(2);
    chk(drive_sel == 1, "R4 limit kept at 3 before third", drive_sel, 1);
    rev();
    chk(drive_sel == 0, "R3 released at 3", drive_sel, 0);

    // R6 collision: activity on the final tick
    do_select();
    revs(2);
    rev(2, 1);
    chk(drive_sel == 1, "R6 activity wins collision", drive_sel, 1);
    revs(3);
    chk(drive_sel == 0, "R6 release after collision", drive_sel, 0);

    // R9: deselected ignores index and activity
    revs(4);
    do_xfer();
    repeat (4) @(negedge clk);
    chk(drive_sel == 0 && head_load == 0, "R9 stays deselected", drive_sel, 0);
    do_select();
    revs(2);
    chk(drive_sel == 1, "R9 count started at zero", drive_sel, 1);
    rev();

    // R3: boundary limit 1
    do_load(1);
    do_select();
    rev();
    chk(drive_sel == 0, "R3 limit 1", drive_sel, 0);

    // R11: lower limit below count
    do_load(16);
    do_select();
    revs(6);
    do_load(3);
    chk(drive_sel == 1, "R11 selected before next rev", drive_sel, 1);
    rev();
    chk(drive_sel == 0, "R11 released next rev", drive_sel, 0);

    // R10: reselect restarts count
    do_load(4);
    do_select();
    revs(3);
    do_select();
    revs(3);
    chk(drive_sel == 1, "R10 reselect restarts", drive_sel, 1);
    rev();

    // R3: boundary limit 255
    do_load(255);
    do_select();
    revs(254);
    chk(drive_sel == 1, "R3 limit 255 held", drive_sel, 1);
    rev();
    chk(drive_sel == 0, "R3 limit 255 release", drive_sel, 0);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all expected events seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule